// File: doc/BRIEF.md
# Twelve-Bit Split Palette Memory

This block is the colour lookup memory of a tile-based video generator. It stores 128 colours of 12 bits each. The CPU reaches the memory through a 256-byte register window, where each colour appears as two 6-bit halves at two separate byte addresses. The pixel pipeline uses a separate port that takes a 7-bit colour index and returns the whole 12-bit colour one clock later.

A mode input selects how the window is decoded:

- **Legacy mode (2 bits per pixel).** The window behaves like a classic 32-entry palette of 6-bit colours, and the upper address bits are folded away.
- **Enhanced mode (4 bits per pixel).** The lower half of the window holds bits 5:0 of all 128 colours. The upper half holds bits 11:6.

In both modes, the sprite backdrop slots of the first 32 low-half entries alias onto the background backdrop slots.

Top module: `split_palette`

## Requirements
- R1: After reset every half-entry reads as zero through the CPU port, and every lookup returns zero.
- R2: A CPU write stores `cpu_wdata[5:0]` into the selected half-entry and ignores `cpu_wdata[7:6]`. A CPU read returns that half-entry in `cpu_rdata[5:0]`, with `cpu_rdata[7:6]` zero.
- R3: In enhanced mode (`enh_mode`=1), addresses 0x00-0x7F select bits 5:0 of colour `cpu_addr[6:0]`, and addresses 0x80-0xFF select bits 11:6 of colour `cpu_addr[6:0]`.
- R4: In both modes, low-half offsets 0x10, 0x14, 0x18 and 0x1C access the same storage as 0x00, 0x04, 0x08 and 0x0C.
- R5: In enhanced mode, addresses 0x20-0xFF never alias. For example, 0x90 and 0x80 are distinct, and 0x30 and 0x20 are distinct.
- R6: In legacy mode (`enh_mode`=0), `cpu_addr[7:5]` is ignored, and every access goes to bits 5:0 of colour `cpu_addr[4:0]`, after the R4 aliasing.
- R7: The lookup port returns `{bits 11:6, bits 5:0}` of colour `pix_idx` on `pix_color` one clock after `pix_idx` is presented. Indices below 0x20 are aliased as in R4.
- R8: In legacy mode, `pix_color[11:6]` is zero, whatever the upper halves hold.
- R9: When a CPU write and a lookup of the same colour fall in the same cycle, the lookup returns the value held before the write.
- R10: CPU reads are combinational. `cpu_rdata` reflects `cpu_addr` and `enh_mode` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all entries |
| enh_mode | input | 1 | 1 = enhanced 4bpp decode, 0 = legacy 2bpp decode |
| cpu_addr | input | 8 | Low byte of the palette window address |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data; bits 5:0 are stored |
| cpu_rdata | output | 8 | CPU read data, bits 7:6 zero |
| pix_idx | input | 7 | Colour index from the pixel pipeline |
| pix_color | output | 12 | Colour fetched for the index of the previous cycle |

## Verification
The embedded assertions check four behaviours on every cycle:

- a written half-entry is read back at the same decoded location on the next cycle;
- legacy decode never selects an upper half;
- no decoded low-half index below 0x20 ever lands on an unaliased sprite backdrop slot;
- legacy lookups carry a zero upper half.

The bench scenarios are needed for the rest. They show the mode-dependent address folding, the absence of mirroring at 0x90 and 0x30, the old-value result of a write and a lookup that collide, and the full pairing of the two halves across all 128 colours.

// File: rtl/spal_pkg.sv
package spal_pkg;

    localparam int unsigned COLOR_IDX_W = 7;
    localparam int unsigned HALF_BITS   = 6;

    typedef logic [COLOR_IDX_W-1:0] color_idx_t;
    typedef logic [HALF_BITS-1:0]   half_t;

    // Sprite backdrop slots (0x10/0x14/0x18/0x1C) fold onto 0x00/0x04/0x08/0x0C
    function automatic color_idx_t fold_backdrop(input color_idx_t idx);
        color_idx_t res;
        res = idx;
        if (idx[COLOR_IDX_W-1:5] == '0 && idx[4] && idx[1:0] == 2'b00)
            res[4] = 1'b0;
        return res;
    endfunction

endpackage

// File: rtl/pal_addr_map.sv
module pal_addr_map
    import spal_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              enh_mode,
    input  logic [ADDR_W-1:0] addr,
    output color_idx_t        idx,
    output logic              sel_hi
);
    localparam int unsigned LEGACY_W = 5;

    color_idx_t raw;

    always_comb begin
        if (enh_mode) begin
            sel_hi = addr[ADDR_W-1];
            raw    = addr[COLOR_IDX_W-1:0];
        end else begin
            sel_hi = 1'b0;
            raw    = {{(COLOR_IDX_W-LEGACY_W){1'b0}}, addr[LEGACY_W-1:0]};
        end
        idx = sel_hi ? raw : fold_backdrop(raw);
    end

endmodule

// File: rtl/pal_store.sv
module pal_store
    import spal_pkg::*;
#(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned HALF_W  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(ENTRIES)-1:0]   wr_idx,
    input  logic                         wr_hi,
    input  logic [HALF_W-1:0]            wr_half,
    input  logic [$clog2(ENTRIES)-1:0]   rd_idx,
    input  logic                         rd_hi,
    output logic [HALF_W-1:0]            rd_half,
    input  logic [$clog2(ENTRIES)-1:0]   lk_idx,
    input  logic                         lk_legacy,
    output logic [2*HALF_W-1:0]          lk_color
);
    localparam int unsigned COLOR_W = 2 * HALF_W;

    typedef struct packed {
        logic [ENTRIES-1:0][HALF_W-1:0] lo;
        logic [ENTRIES-1:0][HALF_W-1:0] hi;
        logic [COLOR_W-1:0]             pix;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lk_legacy)
            st_d.pix = {{HALF_W{1'b0}}, st_q.lo[lk_idx]};
        else
            st_d.pix = {st_q.hi[lk_idx], st_q.lo[lk_idx]};
        if (wr_en) begin
            if (wr_hi)
                st_d.hi[wr_idx] = wr_half;
            else
                st_d.lo[wr_idx] = wr_half;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_half  = rd_hi ? st_q.hi[rd_idx] : st_q.lo[rd_idx];
    assign lk_color = st_q.pix;

    // R2
    write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_idx != $past(wr_idx)) || (rd_hi != $past(wr_hi)) ||
                   (rd_half == $past(wr_half))));

    // R8
    legacy_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_legacy) |-> (lk_color[COLOR_W-1:HALF_W] == '0));

endmodule

// File: rtl/split_palette.sv
module split_palette
    import spal_pkg::*;
#(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned HALF_W  = 6,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enh_mode,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic                        cpu_we,
    input  logic [7:0]                  cpu_wdata,
    output logic [7:0]                  cpu_rdata,
    input  logic [$clog2(ENTRIES)-1:0]  pix_idx,
    output logic [2*HALF_W-1:0]         pix_color
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    color_idx_t          cpu_idx;
    logic                cpu_hi;
    logic [HALF_W-1:0]   rd_half;
    logic [IDX_W-1:0]    lk_idx;

    pal_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .enh_mode (enh_mode),
        .addr     (cpu_addr),
        .idx      (cpu_idx),
        .sel_hi   (cpu_hi)
    );

    assign lk_idx = fold_backdrop(pix_idx);

    pal_store #(.ENTRIES(ENTRIES), .HALF_W(HALF_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cpu_we),
        .wr_idx    (cpu_idx),
        .wr_hi     (cpu_hi),
        .wr_half   (cpu_wdata[HALF_W-1:0]),
        .rd_idx    (cpu_idx),
        .rd_hi     (cpu_hi),
        .rd_half   (rd_half),
        .lk_idx    (lk_idx),
        .lk_legacy (!enh_mode),
        .lk_color  (pix_color)
    );

    assign cpu_rdata = {{(8-HALF_W){1'b0}}, rd_half};

    // R6
    legacy_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_mode |-> !cpu_hi);

    // R4
    backdrop_folded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cpu_hi && cpu_idx[6:5] == 2'b00 && cpu_idx[4] && cpu_idx[1:0] == 2'b00));

endmodule

// File: tb/tb_split_palette.sv
module tb_split_palette;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enh_mode = 1'b1;
    logic [7:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [6:0]  pix_idx = '0;
    logic [11:0] pix_color;

    always #5 clk = ~clk;

    split_palette dut (
        .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .pix_idx(pix_idx), .pix_color(pix_color)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [5:0] m_lo [128];
    logic [5:0] m_hi [128];

    typedef struct {
        logic [11:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    function automatic int fold_i(input int v);
        if (v >= 16 && v < 32 && (v % 4) == 0) return v - 16;
        return v;
    endfunction

    task automatic map_addr(input bit enh, input logic [7:0] a,
                            output int idx, output bit hi);
        if (enh) begin
            hi  = a[7];
            idx = int'(a[6:0]);
        end else begin
            hi  = 1'b0;
            idx = int'(a[4:0]);
        end
        if (!hi) idx = fold_i(idx);
    endtask

    // Driver: one cycle of stimulus; queues the expected lookup, checks CPU read
    task automatic cyc(input bit enh, input bit we, input logic [7:0] a,
                       input logic [7:0] wd, input logic [6:0] lk, input string tag);
        int  idx;
        bit  hi;
        int  li;
        item_t it;
        @(negedge clk);
        enh_mode  = enh;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = wd;
        pix_idx   = lk;
        li = fold_i(int'(lk));
        it.exp = enh ? {m_hi[li], m_lo[li]} : {6'b0, m_lo[li]};
        it.tag = tag;
        sb_q.push_back(it);
        map_addr(enh, a, idx, hi);
        #1;
        if (!we) begin
            logic [7:0] e;
            e = {2'b00, hi ? m_hi[idx] : m_lo[idx]};
            n_chk++;
            if (cpu_rdata !== e) begin
                n_bad++;
                $display("FAIL %s cpu read addr=%02h: got %02h expected %02h", tag, a, cpu_rdata, e);
            end
        end
        @(posedge clk);
        if (we) begin
            if (hi) m_hi[idx] = wd[5:0];
            else    m_lo[idx] = wd[5:0];
        end
    endtask

    // Monitor: compares each lookup result one clock after its index
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (pix_color !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s lookup: got %03h expected %03h", it.tag, pix_color, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            m_lo[i] = '0;
            m_hi[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset
        cyc(1, 0, 8'h00, 8'h00, 7'h00, "R1");
        cyc(1, 0, 8'hFF, 8'h00, 7'h7F, "R1");
        cyc(0, 0, 8'h1F, 8'h00, 7'h33, "R1");

        // R2/R3/R7: halves stored separately, upper data bits dropped
        cyc(1, 1, 8'h05, 8'hFF, 7'h00, "R2");
        cyc(1, 1, 8'h85, 8'hEA, 7'h05, "R3");
        cyc(1, 0, 8'h05, 8'h00, 7'h05, "R2");
        cyc(1, 0, 8'h85, 8'h00, 7'h05, "R7");

        // R4: backdrop aliasing in both modes
        cyc(1, 1, 8'h10, 8'h11, 7'h00, "R4");
        cyc(1, 0, 8'h00, 8'h00, 7'h10, "R4");
        cyc(1, 1, 8'h1C, 8'h2C, 7'h0C, "R4");
        cyc(1, 0, 8'h0C, 8'h00, 7'h1C, "R4");
        cyc(0, 1, 8'h14, 8'h34, 7'h04, "R4");
        cyc(0, 0, 8'h04, 8'h00, 7'h14, "R4");
        cyc(1, 1, 8'h81, 8'h21, 7'h00, "R4");
        cyc(1, 0, 8'h11, 8'h00, 7'h11, "R4");

        // R5: no mirroring above 0x1F
        cyc(1, 1, 8'h80, 8'h0A, 7'h00, "R5");
        cyc(1, 1, 8'h90, 8'h07, 7'h10, "R5");
        cyc(1, 0, 8'h80, 8'h00, 7'h00, "R5");
        cyc(1, 0, 8'h90, 8'h00, 7'h00, "R5");
        cyc(1, 1, 8'h30, 8'h13, 7'h30, "R5");
        cyc(1, 0, 8'h20, 8'h00, 7'h30, "R5");
        cyc(1, 0, 8'h30, 8'h00, 7'h20, "R5");

        // R6: legacy folds address to 5 bits, low half only
        cyc(0, 1, 8'hE3, 8'h1D, 7'h03, "R6");
        cyc(1, 0, 8'h03, 8'h00, 7'h03, "R6");
        cyc(1, 0, 8'h83, 8'h00, 7'h03, "R6");
        cyc(0, 0, 8'hA5, 8'h00, 7'h05, "R6");

        // R8: legacy lookup hides the upper half
        cyc(0, 0, 8'h00, 8'h00, 7'h05, "R8");
        cyc(0, 0, 8'h00, 8'h00, 7'h01, "R8");

        // R9: collision returns old value, then new value
        cyc(1, 1, 8'h05, 8'h2B, 7'h05, "R9");
        cyc(1, 0, 8'h05, 8'h00, 7'h05, "R9");
        cyc(1, 1, 8'h85, 8'h3E, 7'h05, "R9");
        cyc(1, 0, 8'h85, 8'h00, 7'h05, "R9");

        // R7/R10: fill all colours, then sweep lookups and reads
        for (int i = 0; i < 128; i++) begin
            cyc(1, 1, 8'(i), 8'((i * 5 + 3) & 8'hFF), 7'(i), "R7");
            cyc(1, 1, 8'(i + 128), 8'((i * 7 + 1) & 8'hFF), 7'(127 - i), "R7");
        end
        for (int i = 0; i < 128; i++) begin
            cyc(1, 0, 8'(i), 8'h00, 7'(i), "R10");
            cyc(1, 0, 8'(i + 128), 8'h00, 7'(i), "R7");
        end
        for (int i = 0; i < 32; i++) begin
            cyc(0, 0, 8'(i + 64), 8'h00, 7'(i), "R8");
        end

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule